// File: doc/BRIEF.md
# Programmable-Length Serial Delay Register

This block is a one-bit serial delay line whose depth can be set anywhere from 1 to 64 stages. It consists of one fixed head stage followed by six segments of 1, 2, 4, 8, 16 and 32 stages. Each segment is either switched into the chain or bypassed by its own bit of a six-bit length field. The serial input is taken from one of two data pins chosen by a select line. Tying the second data pin back to the output therefore turns the line into a recirculating loop.

Shifts come from a slow external shift clock and an active-low shift enable. Both are sampled by a free-running system clock through two-flop synchronisers. A shift happens on a rising shift clock while the enable is low, or on a falling enable while the shift clock is high. The second case gives falling-edge clocking, and holding the enable high blocks shifting. The block drives the serial output and its complement. A system reset clears every stage.

Top module: `prog_delay_line`

## Requirements
- R1: With length field `len_sel_i` (bit i has weight 2^i), the line depth is L = len_sel_i + 1, from 1 up to 64. A bit shifted in appears on `q_o` after exactly L shifts. Before L shifts have occurred since reset, `q_o` is 0.
- R2: A bypassed segment keeps its contents and does not shift. A change of `len_sel_i` takes effect at the next shift: until then `q_o` still comes from the previously used length.
- R3: When `sel_a_i` is 1, the bit shifted in is `data_a_i`. When it is 0, the bit shifted in is `data_b_i`.
- R4: A rising edge of `shift_clk_i` while `shift_en_n_i` is low causes exactly one shift. Without a qualifying edge the stages do not change.
- R5: A falling edge of `shift_en_n_i` while `shift_clk_i` is high causes exactly one shift. A rising shift clock while the enable is high causes no shift, and a falling enable while the shift clock is low causes no shift.
- R6: A rising shift clock and a falling enable that arrive in the same system clock cycle cause exactly one shift. Two shift events never occur in consecutive system clock cycles.
- R7: `rst_n` low at a system clock edge clears all stages, whatever the level of the shift clock, so `q_o` is 0 and `q_n_o` is 1. The synchronisers restart with the enable seen as high, so releasing reset causes no shift.
- R8: `q_n_o` is always the complement of `q_o`.
- R9: With `sel_a_i` at 0 and `data_b_i` following `q_o`, the stored bits recirculate with a period of L shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| shift_clk_i | input | 1 | Asynchronous shift clock |
| shift_en_n_i | input | 1 | Asynchronous active-low shift enable; its falling edge shifts while shift clock is high |
| sel_a_i | input | 1 | 1 selects data_a_i, 0 selects data_b_i |
| data_a_i | input | 1 | Serial data input A |
| data_b_i | input | 1 | Serial data input B (recirculation path) |
| len_sel_i | input | 6 | Length field, depth = value + 1 |
| q_o | output | 1 | Serial output |
| q_n_o | output | 1 | Complemented serial output |

## Verification
The two shift triggers can land in the same system clock cycle: the shift clock can rise while the enable falls. A double shift there would silently skip a stage. The bench provokes this by moving both pins in the same drive step from an idle state with the shift clock low and the enable high, using a two-stage line loaded from reset. Exactly one shift leaves the output at 0, and a following ordinary shift brings the shifted-in 1 out; a double shift would show the 1 early. Every depth from 1 to 64 is also swept against a delay model, and both trigger modes, recirculation and a reset in the middle of a sequence are covered.

// File: rtl/pdl_pkg.sv
// Package: shared sizing for the programmable delay line.
// Assumes segment i holds 2**i stages, so the chain depth is the
// length field plus the fixed head stage.
package pdl_pkg;
    localparam int SEG_NUM   = 6;
    localparam int MAX_DEPTH = (1 << SEG_NUM);

    // Stage count of segment idx.
    function automatic int seg_len(input int idx);
        return (1 << idx);
    endfunction
endpackage

// File: rtl/pdl_shift_event.sv
// Shift event generator: brings the asynchronous shift clock and the
// active-low enable into the clk domain through two flops each. It then
// flags one cycle per qualifying edge: clock rise with enable low, or
// enable fall with clock high. Assumes both pins are slow relative to clk.
module pdl_shift_event (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic en_n_i,
    output logic shift_o
);
    logic [1:0] sclk_sync;
    logic [1:0] en_sync;
    logic       sclk_prev;
    logic       en_prev;
    logic       sclk_s;
    logic       en_s;
    logic       rise_clk;
    logic       fall_en;

    // Synchronise both pins and keep last synchronised values; enable resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sync <= 2'b00;
            en_sync   <= 2'b11;
            sclk_prev <= 1'b0;
            en_prev   <= 1'b1;
        end else begin
            sclk_sync <= {sclk_sync[0], sclk_i};
            en_sync   <= {en_sync[0], en_n_i};
            sclk_prev <= sclk_sync[1];
            en_prev   <= en_sync[1];
        end
    end

    assign sclk_s = sclk_sync[1];
    assign en_s   = en_sync[1];

    // Qualify the two edge kinds; coincident edges merge into one event.
    always_comb begin
        rise_clk = sclk_s && !sclk_prev && !en_s;
        fall_en  = !en_s && en_prev && sclk_s;
        shift_o  = rise_clk || fall_en;
    end

    // R6
    one_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !shift_o)
        else $error("two shift events in consecutive cycles");
endmodule

// File: rtl/pdl_segment.sv
// Bypassable segment of SEG_LEN stages. It shifts only when a shift
// event occurs and the segment is switched in. Its live tap passes its
// input straight through when bypassed. Assumes din_i is the live tap
// of the preceding part of the chain.
module pdl_segment #(
    parameter int SEG_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic active_i,
    input  logic din_i,
    output logic live_tap_o,
    output logic last_o
);
    logic [SEG_LEN-1:0] stages;

    generate
        if (SEG_LEN == 1) begin : g_single
            // Single stage: load input on an active shift, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)                   stages <= '0;
                else if (shift_i && active_i) stages <= din_i;
            end
        end else begin : g_multi
            // Multi-stage: move toward the last stage on an active shift.
            always_ff @(posedge clk) begin
                if (!rst_n)                   stages <= '0;
                else if (shift_i && active_i) stages <= {stages[SEG_LEN-2:0], din_i};
            end
        end
    endgenerate

    assign last_o     = stages[SEG_LEN-1];
    assign live_tap_o = active_i ? stages[SEG_LEN-1] : din_i;

    // R2
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_i && active_i) |=> $stable(stages))
        else $error("segment changed without an active shift");
endmodule

// File: rtl/prog_delay_line.sv
// Top: programmable-length serial delay line. It has a fixed head stage
// and binary-weighted bypassable segments. The shift path uses the live
// length field; the output tap uses the length captured at the last
// shift, so a new length shows only after the next shift.
// Assumes clk runs much faster than the shift clock and the enable.
module prog_delay_line #(
    parameter int SEGS = pdl_pkg::SEG_NUM
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_clk_i,
    input  logic            shift_en_n_i,
    input  logic            sel_a_i,
    input  logic            data_a_i,
    input  logic            data_b_i,
    input  logic [SEGS-1:0] len_sel_i,
    output logic            q_o,
    output logic            q_n_o
);
    logic            shift_ev;
    logic            head_q;
    logic            din_sel;
    logic [SEGS-1:0] len_q;
    logic [SEGS:0]   live_tap;
    logic [SEGS:0]   out_tap;
    logic [SEGS-1:0] seg_last;

    pdl_shift_event u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (shift_clk_i),
        .en_n_i  (shift_en_n_i),
        .shift_o (shift_ev)
    );

    assign din_sel = sel_a_i ? data_a_i : data_b_i;

    // Head stage loads the selected input; length is captured with each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= 1'b0;
            len_q  <= '0;
        end else if (shift_ev) begin
            head_q <= din_sel;
            len_q  <= len_sel_i;
        end
    end

    assign live_tap[0] = head_q;
    assign out_tap[0]  = head_q;

    generate
        for (genvar i = 0; i < SEGS; i++) begin : g_seg
            pdl_segment #(.SEG_LEN(pdl_pkg::seg_len(i))) u_seg (
                .clk        (clk),
                .rst_n      (rst_n),
                .shift_i    (shift_ev),
                .active_i   (len_sel_i[i]),
                .din_i      (live_tap[i]),
                .live_tap_o (live_tap[i+1]),
                .last_o     (seg_last[i])
            );
            assign out_tap[i+1] = len_q[i] ? seg_last[i] : out_tap[i];
        end
    endgenerate

    assign q_o   = out_tap[SEGS];
    assign q_n_o = !out_tap[SEGS];

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_o && q_n_o))
        else $error("outputs not cleared by reset");

    // R4
    no_stray_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_ev |=> $stable(head_q))
        else $error("head stage changed without a shift event");

    // R3
    head_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ev |=> (head_q == $past(sel_a_i ? data_a_i : data_b_i)))
        else $error("head stage did not load the selected input");
endmodule

// File: tb/prog_delay_line_tb_top.sv
module prog_delay_line_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       shift_clk_i;
    logic       shift_en_n_i;
    logic       sel_a_i;
    logic       data_a_i;
    logic       data_b_i;
    logic [5:0] len_sel_i;
    logic       q_o;
    logic       q_n_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk; // 50 MHz

    prog_delay_line dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_clk_i  (shift_clk_i),
        .shift_en_n_i (shift_en_n_i),
        .sel_a_i      (sel_a_i),
        .data_a_i     (data_a_i),
        .data_b_i     (data_b_i),
        .len_sel_i    (len_sel_i),
        .q_o          (q_o),
        .q_n_o        (q_n_o)
    );

    // Vector: {len code[16:11], sel[10], mode[9], pattern[8:1], expected q[0]}.
    // Pattern is fed MSB first over 8 shifts, so expected q = pattern[code].
    localparam logic [16:0] VEC [8] = '{
        {6'd0, 1'b1, 1'b0, 8'hA5, 1'b1},
        {6'd1, 1'b0, 1'b0, 8'hA5, 1'b0},
        {6'd2, 1'b1, 1'b1, 8'hA5, 1'b1},
        {6'd3, 1'b0, 1'b1, 8'h3C, 1'b1},
        {6'd4, 1'b1, 1'b0, 8'h3C, 1'b1},
        {6'd5, 1'b0, 1'b1, 8'h0F, 1'b0},
        {6'd6, 1'b1, 1'b1, 8'h40, 1'b1},
        {6'd7, 1'b0, 1'b0, 8'h7F, 1'b0}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req, input logic exp);
        check(req, q_o, exp);
        check({req, " R8"}, q_n_o, ~exp);
    endtask

    // Idle for mode 0 (clock low, enable low) or mode 1 (clock high, enable high).
    task automatic idle(input logic mode);
        if (!mode) begin
            shift_clk_i = 1'b0; wait_cyc(4);
            shift_en_n_i = 1'b0; wait_cyc(4);
        end else begin
            shift_en_n_i = 1'b1; wait_cyc(4);
            shift_clk_i = 1'b1; wait_cyc(4);
        end
    endtask

    task automatic pulse(input logic mode);
        if (!mode) begin
            shift_clk_i = 1'b1; wait_cyc(4);
            shift_clk_i = 1'b0; wait_cyc(4);
        end else begin
            shift_en_n_i = 1'b0; wait_cyc(4);
            shift_en_n_i = 1'b1; wait_cyc(4);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; wait_cyc(2);
        rst_n = 1'b1; wait_cyc(2);
    endtask

    function automatic logic dbit(input int k);
        return logic'(((k * 5) ^ (k >> 1) ^ (k >> 3)) & 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; shift_clk_i = 1'b0; shift_en_n_i = 1'b1;
        sel_a_i = 1'b1; data_a_i = 1'b0; data_b_i = 1'b0; len_sel_i = '0;
        wait_cyc(3);
        check_out("R7 reset state", 1'b0);
        rst_n = 1'b1; wait_cyc(2);

        // Table walk: lengths 1..8, both inputs, both trigger modes (R1 R3 R4 R5).
        for (int v = 0; v < 8; v++) begin
            logic [16:0] e;
            e = VEC[v];
            idle(e[9]);
            do_reset;
            len_sel_i = e[16:11];
            sel_a_i   = e[10];
            for (int k = 7; k >= 0; k--) begin
                data_a_i = e[10] ? e[1+k] : ~e[1+k];
                data_b_i = e[10] ? ~e[1+k] : e[1+k];
                pulse(e[9]);
            end
            check_out("R1 R3 R4 R5 table vector", e[0]);
        end

        // Full depth sweep against a delay model (R1).
        sel_a_i = 1'b1;
        for (int L = 1; L <= 64; L++) begin
            idle(1'b0);
            do_reset;
            len_sel_i = 6'(L - 1);
            for (int n = 1; n <= L + 4; n++) begin
                data_a_i = dbit(n);
                pulse(1'b0);
                check_out("R1 depth sweep", (n >= L) ? dbit(n - L + 1) : 1'b0);
            end
        end

        // Enable gating (R5): blocked rise, fall with clock low, then fall with clock high.
        shift_clk_i = 1'b0; shift_en_n_i = 1'b1; wait_cyc(4);
        do_reset;
        len_sel_i = 6'd0; data_a_i = 1'b1;
        shift_clk_i = 1'b1; wait_cyc(4);
        check_out("R5 rise with enable high blocked", 1'b0);
        shift_clk_i = 1'b0; wait_cyc(4);
        shift_en_n_i = 1'b0; wait_cyc(4);
        check_out("R5 enable fall with clock low ignored", 1'b0);
        shift_en_n_i = 1'b1; wait_cyc(4);
        shift_clk_i = 1'b1; wait_cyc(4);
        shift_en_n_i = 1'b0; wait_cyc(4);
        check_out("R5 enable fall with clock high shifts", 1'b1);

        // Coincident edges give one shift (R6).
        shift_clk_i = 1'b0; shift_en_n_i = 1'b1; wait_cyc(4);
        do_reset;
        len_sel_i = 6'd1; data_a_i = 1'b1;
        shift_clk_i = 1'b1; shift_en_n_i = 1'b0; wait_cyc(6);
        check_out("R6 coincident edges single shift", 1'b0);
        shift_clk_i = 1'b0; wait_cyc(4);
        data_a_i = 1'b0;
        pulse(1'b0);
        check_out("R6 bit emerges after second shift", 1'b1);

        // Length change and bypass retention (R2).
        idle(1'b0);
        do_reset;
        len_sel_i = 6'd2;
        data_a_i = 1'b1; pulse(1'b0);
        data_a_i = 1'b1; pulse(1'b0);
        data_a_i = 1'b0; pulse(1'b0);
        check_out("R2 loaded depth 3", 1'b1);
        len_sel_i = 6'd0; wait_cyc(3);
        check_out("R2 new length waits for shift", 1'b1);
        data_a_i = 1'b0; pulse(1'b0);
        check_out("R2 depth 1 after shift", 1'b0);
        len_sel_i = 6'd2;
        pulse(1'b0);
        check_out("R2 bypassed segment retained", 1'b1);

        // Recirculation through input B, depth 5 (R9).
        begin
            logic [4:0] rc;
            rc = 5'b10110;
            idle(1'b0);
            do_reset;
            len_sel_i = 6'd4; sel_a_i = 1'b1;
            for (int j = 4; j >= 0; j--) begin
                data_a_i = rc[j];
                pulse(1'b0);
            end
            check_out("R9 loaded", rc[4]);
            sel_a_i = 1'b0; data_a_i = 1'b0;
            for (int m = 1; m <= 10; m++) begin
                data_b_i = q_o;
                pulse(1'b0);
                check_out("R9 recirculate", rc[4 - (m % 5)]);
            end
        end

        // Reset mid-sequence with shift clock high (R7).
        sel_a_i = 1'b1;
        idle(1'b0);
        len_sel_i = 6'd3; data_a_i = 1'b1;
        for (int j = 0; j < 4; j++) pulse(1'b0);
        check_out("R7 line filled", 1'b1);
        idle(1'b1);
        rst_n = 1'b0; wait_cyc(1);
        check_out("R7 cleared while shift clock high", 1'b0);
        rst_n = 1'b1; wait_cyc(4);
        check_out("R7 no shift on release", 1'b0);
        idle(1'b0);
        for (int j = 1; j <= 4; j++) begin
            pulse(1'b0);
            check_out("R7 chain truly cleared", (j == 4) ? 1'b1 : 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule